// File: doc/BRIEF.md
# Per-Way Recency Bit Replacement Selector

This block chooses which way of a set-associative cache is to be refilled. Each set keeps one recency flag per way. A hit on a way raises that way's flag. A miss nominates a victim, which is the lowest-numbered way whose flag is low, and the refill then raises the victim's flag. An update can leave every flag of the set high. When it would, the set is cut back so that only the way just touched keeps its flag. A set therefore always holds at least one candidate victim.

The surrounding cache controller keeps the tags and the data. Each cycle it presents a set index. It raises a hit strobe with the hit way when the lookup matched, and a miss strobe when a refill takes place. The nominated victim and the flag vector of the indexed set are read combinationally from the stored state. Updates are committed on the rising clock edge.

Top module: `way_recency_repl`

## Requirements
- R1: After an active-low reset, every flag of every set reads 0, and every set nominates way 0 as victim.
- R2: A hit on a way whose flag is 0 sets that flag. The other flags are kept unless R6 applies. The change shows on `mru_bits_dbg` one clock after the hit is sampled.
- R3: A hit on a way whose flag is already 1 leaves the set's vector unchanged.
- R4: `victim_way` is the index of the lowest-numbered way whose flag is 0 in the set selected by `set_idx`. It follows the current state with no clock delay.
- R5: A miss strobe without a hit strobe sets the flag of the way nominated in that cycle. The change is visible one clock later.
- R6: If setting the accessed way's flag would make all flags of the set 1, the stored vector becomes a one-hot vector holding only the accessed way's flag.
- R7: The flag vector of any set never reads all ones.
- R8: When `hit_valid` and `miss_req` are high in the same cycle, only the hit update is applied and the miss strobe has no effect.
- R9: An update changes only the set indexed in that cycle. Every other set keeps its vector.
- R10: `mru_bits_dbg` bit i is the flag of way i in the set selected by `set_idx`, read without clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| set_idx | input | SET_W | Set addressed this cycle |
| hit_valid | input | 1 | Lookup hit strobe |
| hit_way | input | WAY_W | Way that hit |
| miss_req | input | 1 | Refill strobe; the nominated victim is filled |
| victim_way | output | WAY_W | Nominated victim of the indexed set |
| mru_bits_dbg | output | NUM_WAYS | Flag vector of the indexed set |

## Verification
The victim and the flag vector follow `set_idx` and the stored state in the same cycle with no delay. An access sampled on a rising edge shows in both outputs from that edge onward, so its result is due one cycle later. The bench drives every access on the falling edge. It compares both outputs against its own model a short delay after that edge, before the next rising edge. The model is then advanced at that rising edge. As a result each comparison sees exactly the accesses committed so far. Directed checks revisit a set on a later idle cycle to observe the effect of the previous access.

// File: rtl/way_recency_pkg.sv
// Package: shared types of the per-way recency replacement selector.
// Assumes nothing beyond IEEE 1800-2017.
package way_recency_pkg;

    // Kind of update applied to the indexed set this cycle.
    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_HIT  = 2'd1,
        ACC_FILL = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/wr_access_arb.sv
// Module: wr_access_arb
// Chooses the update for this cycle from the hit and refill strobes.
// A hit takes priority: a refill strobe seen together with a hit is dropped.
// The refill way is the victim nominated for the current state.
// Assumes both strobes come from one controller and share set_idx.
module wr_access_arb
    import way_recency_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic             hit_valid,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             miss_req,
    input  logic [WAY_W-1:0] victim_way,
    output acc_kind_e        acc_kind,
    output logic [WAY_W-1:0] acc_way
);

    // Priority decode: hit first, refill second, otherwise idle.
    always_comb begin
        acc_kind = ACC_IDLE;
        acc_way  = '0;
        if (hit_valid) begin
            acc_kind = ACC_HIT;
            acc_way  = hit_way;
        end else if (miss_req) begin
            acc_kind = ACC_FILL;
            acc_way  = victim_way;
        end
    end

endmodule

// File: rtl/wr_victim_find.sv
// Module: wr_victim_find
// Finds the lowest-numbered way whose recency flag is low.
// Built as a prefix chain: way i is chosen when its flag is low and all lower
// flags are high. Assumes the vector is never all ones. If it were, found is
// low and index 0 is returned.
module wr_victim_find #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0] flags,
    output logic [WAY_W-1:0]    victim,
    output logic                found
);

    logic [NUM_WAYS:0]   lower_full;
    logic [NUM_WAYS-1:0] pick;

    assign lower_full[0] = 1'b1;

    genvar g;
    generate
        for (g = 0; g < NUM_WAYS; g++) begin : g_chain
            // Way g wins when it is free and every lower way is taken.
            assign pick[g]           = lower_full[g] & ~flags[g];
            assign lower_full[g + 1] = lower_full[g] & flags[g];
        end
    endgenerate

    // One-hot pick to binary index.
    always_comb begin
        victim = '0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            if (pick[i]) begin
                victim = victim | WAY_W'(i);
            end
        end
    end

    // Flag that a free way exists.
    assign found = ~lower_full[NUM_WAYS];

endmodule

// File: rtl/wr_bit_update.sv
// Module: wr_bit_update
// Computes the next flag vector of one set for a given access.
// The accessed way's flag is raised. If that would fill the vector, only
// the accessed way's flag is kept. Idle cycles produce no write.
module wr_bit_update
    import way_recency_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0] cur_flags,
    input  acc_kind_e           acc_kind,
    input  logic [WAY_W-1:0]    acc_way,
    output logic [NUM_WAYS-1:0] next_flags,
    output logic                wr_en
);

    logic [NUM_WAYS-1:0] way_onehot;
    logic [NUM_WAYS-1:0] raised;
    logic                would_fill;

    // Decode the accessed way into a one-hot mask.
    always_comb begin
        way_onehot = '0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            way_onehot[i] = (acc_way == WAY_W'(i));
        end
    end

    assign raised     = cur_flags | way_onehot;
    assign would_fill = &raised;

    // Select the vector to store and whether to store it.
    always_comb begin
        wr_en      = (acc_kind != ACC_IDLE);
        next_flags = cur_flags;
        if (wr_en) begin
            next_flags = would_fill ? way_onehot : raised;
        end
    end

endmodule

// File: rtl/wr_bit_store.sv
// Module: wr_bit_store
// Holds one flag vector per set, clears all of them on synchronous
// active-low reset, and gives one combinational read port and one write port.
// Read and write share the same index.
module wr_bit_store #(
    parameter int NUM_WAYS = 4,
    parameter int NUM_SETS = 16,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SET_W-1:0]    idx,
    input  logic                wr_en,
    input  logic [NUM_WAYS-1:0] wr_flags,
    output logic [NUM_WAYS-1:0] rd_flags
);

    logic [NUM_WAYS-1:0] flag_mem [NUM_SETS];

    // Clear on reset, otherwise write the indexed set when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                flag_mem[s] <= '0;
            end
        end else if (wr_en) begin
            flag_mem[idx] <= wr_flags;
        end
    end

    // Combinational read of the indexed set.
    assign rd_flags = flag_mem[idx];

endmodule

// File: rtl/way_recency_repl.sv
// Module: way_recency_repl (top)
// Per-way recency flag replacement selector for a set-associative cache.
// Assumes NUM_WAYS >= 2 and NUM_SETS >= 2, both powers of two. The caller
// keeps tag and data storage. Updates commit on the rising edge. The victim
// and the debug vector are combinational from set_idx and the stored state.
module way_recency_repl
    import way_recency_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int NUM_SETS = 16,
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SET_W-1:0]    set_idx,
    input  logic                hit_valid,
    input  logic [WAY_W-1:0]    hit_way,
    input  logic                miss_req,
    output logic [WAY_W-1:0]    victim_way,
    output logic [NUM_WAYS-1:0] mru_bits_dbg
);

    logic [NUM_WAYS-1:0] cur_flags;
    logic [NUM_WAYS-1:0] next_flags;
    logic                wr_en;
    logic                victim_found;
    acc_kind_e           acc_kind;
    logic [WAY_W-1:0]    acc_way;

    wr_bit_store #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (set_idx),
        .wr_en    (wr_en),
        .wr_flags (next_flags),
        .rd_flags (cur_flags)
    );

    wr_victim_find #(.NUM_WAYS(NUM_WAYS)) find_i (
        .flags  (cur_flags),
        .victim (victim_way),
        .found  (victim_found)
    );

    wr_access_arb #(.NUM_WAYS(NUM_WAYS)) arb_i (
        .hit_valid  (hit_valid),
        .hit_way    (hit_way),
        .miss_req   (miss_req),
        .victim_way (victim_way),
        .acc_kind   (acc_kind),
        .acc_way    (acc_way)
    );

    wr_bit_update #(.NUM_WAYS(NUM_WAYS)) upd_i (
        .cur_flags  (cur_flags),
        .acc_kind   (acc_kind),
        .acc_way    (acc_way),
        .next_flags (next_flags),
        .wr_en      (wr_en)
    );

    assign mru_bits_dbg = cur_flags;

endmodule

// File: rtl/way_recency_repl_chk.sv
// Module: way_recency_repl_chk
// Assertion checker attached to way_recency_repl through bind.
// It observes ports only and keeps a one-cycle flag so that no $past
// reaches before reset.
module way_recency_repl_chk #(
    parameter int NUM_WAYS = 4,
    parameter int NUM_SETS = 16,
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [SET_W-1:0]    set_idx,
    input logic                hit_valid,
    input logic [WAY_W-1:0]    hit_way,
    input logic                miss_req,
    input logic [WAY_W-1:0]    victim_way,
    input logic [NUM_WAYS-1:0] mru_bits_dbg
);

    logic live;

    // Marks cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    // R7: a set never reads all ones.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(&mru_bits_dbg));

    // R4: the nominated way is free.
    p_victim_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mru_bits_dbg[victim_way]);

    // R2: after a hit on the same set, the hit way's flag is high.
    p_hit_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(hit_valid) && set_idx == $past(set_idx))
        |-> mru_bits_dbg[$past(hit_way)]);

    // R5: after a refill without hit, the former victim's flag is high.
    p_fill_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(miss_req) && !$past(hit_valid) && set_idx == $past(set_idx))
        |-> mru_bits_dbg[$past(victim_way)]);

    // R6: filling the last free flag leaves a one-hot vector.
    p_wrap_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(hit_valid) && set_idx == $past(set_idx)
         && $past($countones(mru_bits_dbg)) == NUM_WAYS - 1
         && !$past(mru_bits_dbg[hit_way]))
        |-> $countones(mru_bits_dbg) == 1);

    // R9: an idle cycle leaves the revisited set unchanged.
    p_idle_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !$past(hit_valid) && !$past(miss_req) && set_idx == $past(set_idx))
        |-> $stable(mru_bits_dbg));

endmodule

bind way_recency_repl way_recency_repl_chk #(
    .NUM_WAYS (NUM_WAYS),
    .NUM_SETS (NUM_SETS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_idx      (set_idx),
    .hit_valid    (hit_valid),
    .hit_way      (hit_way),
    .miss_req     (miss_req),
    .victim_way   (victim_way),
    .mru_bits_dbg (mru_bits_dbg)
);

// File: tb/way_recency_repl_tb_top.sv
// Bench for way_recency_repl: directed corner cases, then seeded random
// traffic compared against a behavioural model kept in bench functions.
module way_recency_repl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;
    localparam int NS = 16;
    localparam int WW = $clog2(NW);
    localparam int SW = $clog2(NS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] set_idx = '0;
    logic          hit_valid = 1'b0;
    logic [WW-1:0] hit_way = '0;
    logic          miss_req = 1'b0;
    logic [WW-1:0] victim_way;
    logic [NW-1:0] mru_bits_dbg;

    int checks = 0;
    int errors = 0;
    logic [NW-1:0] model [NS];

    always #(CLK_PERIOD / 2) clk = ~clk;

    way_recency_repl #(.NUM_WAYS(NW), .NUM_SETS(NS)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_idx      (set_idx),
        .hit_valid    (hit_valid),
        .hit_way      (hit_way),
        .miss_req     (miss_req),
        .victim_way   (victim_way),
        .mru_bits_dbg (mru_bits_dbg)
    );

    function automatic logic [WW-1:0] lowest_free(input logic [NW-1:0] v);
        for (int i = NW - 1; i >= 0; i--) begin
            if (!v[i]) lowest_free = WW'(i);
        end
        if (&v) lowest_free = '0;
    endfunction

    function automatic logic [NW-1:0] touch(input logic [NW-1:0] v, input logic [WW-1:0] w);
        logic [NW-1:0] oh = NW'(1) << w;
        logic [NW-1:0] r  = v | oh;
        touch = (&r) ? oh : r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one access at the falling edge, compare outputs, let it commit.
    task automatic step(input int s, input bit hv, input int hw, input bit mr);
        @(negedge clk);
        set_idx = SW'(s); hit_valid = hv; hit_way = WW'(hw); miss_req = mr;
        #1;
        check("R10 vector", 32'(mru_bits_dbg), 32'(model[s]));
        check("R4 victim", 32'(victim_way), 32'(lowest_free(model[s])));
        check("R7 never full", 32'(&mru_bits_dbg), 32'd0);
        if (hv)      model[s] = touch(model[s], WW'(hw));
        else if (mr) model[s] = touch(model[s], lowest_free(model[s]));
        @(posedge clk);
    endtask

    // Idle look at a set; compare against a literal expected vector.
    task automatic peek(input int s, input string tag, input logic [NW-1:0] exp);
        @(negedge clk);
        set_idx = SW'(s); hit_valid = 1'b0; miss_req = 1'b0;
        #1;
        check(tag, 32'(mru_bits_dbg), 32'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int s = 0; s < NS; s++) model[s] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every set empty after reset, victim way 0.
        for (int s = 0; s < NS; s++) begin
            peek(s, "R1 reset vector", 4'b0000);
            check("R1 reset victim", 32'(victim_way), 32'd0);
        end

        // R2: hit on free way 1 of set 3.
        step(3, 1, 1, 0);
        peek(3, "R2 hit sets flag", 4'b0010);
        // R3: repeat hit leaves vector alone.
        step(3, 1, 1, 0);
        peek(3, "R3 repeat hit", 4'b0010);
        // R4/R5: refill picks way 0, then way 2.
        check("R4 lowest free", 32'(victim_way), 32'd0);
        step(3, 0, 0, 1);
        peek(3, "R5 refill sets victim", 4'b0011);
        check("R4 next lowest free", 32'(victim_way), 32'd2);
        step(3, 0, 0, 1);
        peek(3, "R5 second refill", 4'b0111);
        // R6: refill of last free way wraps to one-hot.
        check("R4 last free", 32'(victim_way), 32'd3);
        step(3, 0, 0, 1);
        peek(3, "R6 refill wrap", 4'b1000);
        // R6 via hit.
        step(3, 1, 0, 0);
        step(3, 1, 1, 0);
        step(3, 1, 2, 0);
        peek(3, "R6 hit wrap", 4'b0100);
        // R8: hit and refill together: only hit way 3 raised.
        step(3, 1, 3, 1);
        peek(3, "R8 hit wins", 4'b1100);
        // R9: neighbours untouched.
        peek(2, "R9 set 2 untouched", 4'b0000);
        peek(4, "R9 set 4 untouched", 4'b0000);

        // Random traffic over all sets.
        for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom % 3);
            step(int'($urandom % NS), r == 1, int'($urandom % NW),
                 r == 2 || ($urandom % 8 == 0));
        end
        // R9: final sweep of all sets against the model.
        for (int s = 0; s < NS; s++) peek(s, "R9 final sweep", model[s]);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule